// File: doc/BRIEF.md
# Write-Masked GPIO Port Register Set

This block holds the software-visible state of a 32-pin general-purpose I/O port on a plain 32-bit memory-mapped bus with an address, a write strobe, write data and combinational read data. It keeps two pin-wide registers: the level each pin drives, and the direction of each pin. It also presents the synchronized levels seen on the pins and a fixed identification word.

Each pin-wide register is split into two 16-bit halves at neighbouring word addresses. In every write, bits 31:16 are a per-bit enable for bits 15:0. A single pin can therefore be driven, released or turned around with one store, and no read-modify-write sequence is needed, even when several agents share the port. Interrupt detection and input filtering are handled by separate blocks that consume `pin_oe`, `pin_out` and the synchronized levels.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, `pin_out` and `pin_oe` are all zero (every pin an input, driving 0), and reads of the four half-register addresses return 0.
- R2: A write to address 0x00 sets output bit i (i = 0..15) to write-data bit i only when write-data bit i+16 is 1. Every other output bit keeps its value.
- R3: A write to address 0x04 updates output bits 16..31 using the same mask rule. Write-data bit j is the value for pin 16+j, and bit j+16 is its enable.
- R4: Addresses 0x08 (pins 0..15) and 0x0C (pins 16..31) hold the direction register under the same mask rule. A direction bit of 1 drives that pin's `pin_oe` high (output) and 0 makes the pin an input.
- R5: A read of any half-register address returns that half in bits 15:0 and 0 in bits 31:16. The full value is therefore (word at base+4 << 16) | word at base.
- R6: A read of address 0x70 returns all 32 pin levels after a two-flop synchronizer, so a change on `pin_in` shows up after two rising clock edges. Writes to 0x70 change no state.
- R7: A read of address 0x78 returns the constant identification word 0x01000C2B (major 0x01 in bits 31:24, minor 0x00 in bits 23:16, revision 0x0C2B in bits 15:0). Writes to 0x78 change no state.
- R8: A write to any other address changes no state, and a read of any other address returns 0.
- R9: A write whose enable bits 31:16 are all zero leaves the addressed half unchanged.
- R10: A read of an address in the same cycle as a write to it returns the value from before the write. The new value is readable from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data: enables in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Output enable per pin, 1 = output |

## Verification
A write and a read of the same half-register can happen in the same cycle, because the read path is combinational and the write lands on the clock edge. The bench holds the write strobe and address, samples the read data before the edge and expects the old contents. After the edge it samples again at the same address and expects the masked update. Constrained random writes to all mapped and unmapped addresses are compared against a bench-side model of both registers after every access.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned HALF_W = BUS_W / 2;

   // word offsets; a register's upper half is always at base + 4
   localparam int unsigned OFS_DOUT    = 'h00;
   localparam int unsigned OFS_DIR     = 'h08;
   localparam int unsigned OFS_EXT     = 'h70;
   localparam int unsigned OFS_VERSION = 'h78;
   localparam int unsigned HALF_STRIDE = 4;

   localparam logic [BUS_W-1:0] DEFAULT_VERSION = 32'h0100_0C2B;

   // merge of a masked half-word write
   function automatic logic [HALF_W-1:0] masked_merge(
      input logic [HALF_W-1:0] cur,
      input logic [HALF_W-1:0] val,
      input logic [HALF_W-1:0] en);
      return (cur & ~en) | (val & en);
   endfunction
endpackage

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = HALF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wval,
   input  logic [WIDTH-1:0] wmask,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (WIDTH == HALF_W)
         else $fatal(1, "gpio_mask_reg: WIDTH must equal HALF_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_sel) begin
         q <= masked_merge(q, wval, wmask);
      end
   end

   // R2: bits whose enable is clear keep their value
   p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> (((q ^ $past(q)) & ~$past(wmask)) == '0));

   // R2: bits whose enable is set take the written value
   p_masked_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> (((q ^ $past(wval)) & $past(wmask)) == '0));

   // R9/R8: without a select the half never moves
   p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel |=> $stable(q));

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   initial begin
      assert (STAGES >= 2)
         else $fatal(1, "gpio_pin_sync: at least two stages required");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
      end
   end

   assign sync_out = chain[STAGES-1];

   generate
      if (STAGES == 2) begin : g_chk2
         logic [1:0] warm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          warm <= 2'd0;
            else if (warm != 2'd2) warm <= warm + 2'd1;
         end
         // R6: pin level appears after exactly two edges
         p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (warm == 2'd2) |-> (sync_out == $past(async_in, 2)));
      end
   endgenerate

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_port_pkg::*;
#(
   parameter int unsigned NUM_HALF = 2,
   parameter logic [BUS_W-1:0] VERSION = DEFAULT_VERSION
) (
   input  logic [NUM_HALF-1:0]             hit_dout,
   input  logic [NUM_HALF-1:0]             hit_dir,
   input  logic                            hit_ext,
   input  logic                            hit_ver,
   input  logic [NUM_HALF*HALF_W-1:0]      dout_q,
   input  logic [NUM_HALF*HALF_W-1:0]      dir_q,
   input  logic [NUM_HALF*HALF_W-1:0]      ext_q,
   output logic [BUS_W-1:0]                rdata
);

   localparam int unsigned PINS = NUM_HALF * HALF_W;

   always_comb begin
      rdata = '0;
      for (int h = 0; h < NUM_HALF; h++) begin
         if (hit_dout[h]) rdata = rdata | {{HALF_W{1'b0}}, dout_q[h*HALF_W +: HALF_W]};
         if (hit_dir[h])  rdata = rdata | {{HALF_W{1'b0}}, dir_q[h*HALF_W +: HALF_W]};
      end
      if (hit_ext) rdata = rdata | BUS_W'(ext_q[PINS-1:0]);
      if (hit_ver) rdata = rdata | VERSION;
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PINS        = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [31:0] VERSION     = DEFAULT_VERSION
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);

   localparam int unsigned NUM_HALF = PINS / HALF_W;

   initial begin
      assert (NUM_HALF == 2 && PINS == NUM_HALF * HALF_W)
         else $fatal(1, "gpio_port_regs: PINS must fill two half-words");
      assert (ADDR_W >= 7)
         else $fatal(1, "gpio_port_regs: ADDR_W too small for the map");
   end

   logic [NUM_HALF-1:0] hit_dout, hit_dir;
   logic                hit_ext, hit_ver;
   logic [PINS-1:0]     dout_q, dir_q, ext_q;

   // address decode
   always_comb begin
      for (int h = 0; h < NUM_HALF; h++) begin
         hit_dout[h] = (bus_addr == ADDR_W'(OFS_DOUT + h * HALF_STRIDE));
         hit_dir[h]  = (bus_addr == ADDR_W'(OFS_DIR  + h * HALF_STRIDE));
      end
      hit_ext = (bus_addr == ADDR_W'(OFS_EXT));
      hit_ver = (bus_addr == ADDR_W'(OFS_VERSION));
   end

   genvar h;
   generate
      for (h = 0; h < NUM_HALF; h++) begin : g_half
         gpio_mask_reg #(.WIDTH(HALF_W)) u_dout (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_sel(bus_wr_en && hit_dout[h]),
            .wval  (bus_wdata[HALF_W-1:0]),
            .wmask (bus_wdata[BUS_W-1:HALF_W]),
            .q     (dout_q[h*HALF_W +: HALF_W])
         );
         gpio_mask_reg #(.WIDTH(HALF_W)) u_dir (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_sel(bus_wr_en && hit_dir[h]),
            .wval  (bus_wdata[HALF_W-1:0]),
            .wmask (bus_wdata[BUS_W-1:HALF_W]),
            .q     (dir_q[h*HALF_W +: HALF_W])
         );
      end
   endgenerate

   gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(pin_in),
      .sync_out(ext_q)
   );

   gpio_read_mux #(.NUM_HALF(NUM_HALF), .VERSION(VERSION)) u_rmux (
      .hit_dout(hit_dout),
      .hit_dir (hit_dir),
      .hit_ext (hit_ext),
      .hit_ver (hit_ver),
      .dout_q  (dout_q),
      .dir_q   (dir_q),
      .ext_q   (ext_q),
      .rdata   (bus_rdata)
   );

   assign pin_out = dout_q;
   assign pin_oe  = dir_q;

   // R5: half-register reads carry nothing above bit 15
   p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hit_dout) || (|hit_dir)) |-> (bus_rdata[31:16] == 16'h0));

   // R7: identification word is constant
   p_version_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ver |-> (bus_rdata == VERSION));

   // R4: direction register only moves on a write to its own halves
   p_dir_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_en && (|hit_dir)) |=> $stable(pin_oe));

endmodule

// File: tb/gpio_port_regs_bench.sv
`timescale 1ns/1ps
module gpio_port_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] m_dout = '0;
   logic [31:0] m_dir  = '0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_port_regs u_gpio_port_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   function automatic logic [15:0] merge16(input logic [15:0] cur, input logic [31:0] d);
      return (cur & ~d[31:16]) | (d[15:0] & d[31:16]);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] ext);
      case (a)
         8'h00: return {16'h0, m_dout[15:0]};
         8'h04: return {16'h0, m_dout[31:16]};
         8'h08: return {16'h0, m_dir[15:0]};
         8'h0C: return {16'h0, m_dir[31:16]};
         8'h70: return ext;
         8'h78: return 32'h0100_0C2B;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      case (a)
         8'h00: m_dout[15:0]  = merge16(m_dout[15:0], d);
         8'h04: m_dout[31:16] = merge16(m_dout[31:16], d);
         8'h08: m_dir[15:0]   = merge16(m_dir[15:0], d);
         8'h0C: m_dir[31:16]  = merge16(m_dir[31:16], d);
         default: ;
      endcase
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(posedge clk);
      #1;
      bus_wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] ext);
      @(negedge clk);
      bus_addr = a; bus_wr_en = 1'b0;
      #1;
      check(tag, bus_rdata, exp_read(a, ext));
   endtask

   task automatic pins_check(input string tag);
      check({tag, " pin_out"}, pin_out, m_dout);
      check({tag, " pin_oe"},  pin_oe,  m_dir);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] seed_sink;
      logic [7:0]  addrs [8];
      seed_sink = $urandom(32'd20240611);
      addrs[0] = 8'h00; addrs[1] = 8'h04; addrs[2] = 8'h08; addrs[3] = 8'h0C;
      addrs[4] = 8'h70; addrs[5] = 8'h78; addrs[6] = 8'h10; addrs[7] = 8'h3C;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      pins_check("R1 reset");
      read_check("R1 read dout lo", 8'h00, 32'h0);
      read_check("R1 read dout hi", 8'h04, 32'h0);
      read_check("R1 read dir lo",  8'h08, 32'h0);
      read_check("R1 read dir hi",  8'h0C, 32'h0);

      // R2: single-bit set and clear in the low half
      do_write(8'h00, 32'h0001_0001);
      pins_check("R2 set bit0");
      do_write(8'h00, 32'h0080_FFFF);
      pins_check("R2 set bit7 only");
      do_write(8'h00, 32'h0001_0000);
      pins_check("R2 clear bit0");
      read_check("R2 readback", 8'h00, 32'h0);

      // R9: zero enable mask
      do_write(8'h00, 32'h0000_FFFF);
      pins_check("R9 zero mask");

      // R3: high half
      do_write(8'h04, 32'h8001_FFFF);
      pins_check("R3 bits 16 and 31");
      read_check("R3 readback", 8'h04, 32'h0);

      // R4: direction halves
      do_write(8'h08, 32'hFFFF_A5A5);
      do_write(8'h0C, 32'h00F0_0030);
      pins_check("R4 direction");
      read_check("R5 dir lo upper zero", 8'h08, 32'h0);
      read_check("R5 dir hi upper zero", 8'h0C, 32'h0);

      // R10: same-cycle read and write
      @(negedge clk);
      bus_addr = 8'h00; bus_wdata = 32'hFFFF_1234; bus_wr_en = 1'b1;
      #1 check("R10 pre-write read", bus_rdata, {16'h0, m_dout[15:0]});
      @(posedge clk);
      #1 bus_wr_en = 1'b0;
      model_write(8'h00, 32'hFFFF_1234);
      check("R10 post-write read", bus_rdata, 32'h0000_1234);

      // R6: synchronizer latency and write immunity
      @(negedge clk);
      pin_in = 32'hDEAD_BEEF;
      bus_addr = 8'h70;
      @(posedge clk); #1;
      check("R6 one edge not yet", bus_rdata, 32'h0);
      @(posedge clk); #1;
      check("R6 two edges", bus_rdata, 32'hDEAD_BEEF);
      do_write(8'h70, 32'hFFFF_FFFF);
      pins_check("R6 write ignored");
      read_check("R6 ext after write", 8'h70, 32'hDEAD_BEEF);

      // R7: identification word
      read_check("R7 version", 8'h78, 32'h0);
      do_write(8'h78, 32'hFFFF_0000);
      pins_check("R7 write ignored");
      read_check("R7 version after write", 8'h78, 32'h0);

      // R8: unmapped addresses
      do_write(8'h10, 32'hFFFF_FFFF);
      do_write(8'h7C, 32'hFFFF_0000);
      do_write(8'h02, 32'hFFFF_FFFF);
      pins_check("R8 unmapped writes");
      read_check("R8 unmapped read 0x10", 8'h10, 32'h0);
      read_check("R8 unmapped read 0x7C", 8'h7C, 32'h0);

      // random traffic (R2, R3, R4, R5, R9)
      for (int i = 0; i < 400; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         a = addrs[$urandom_range(0, 7)];
         d = $urandom();
         if ($urandom_range(0, 7) == 0) d[31:16] = 16'h0;
         do_write(a, d);
         pins_check("R2/R3/R4 random");
         read_check("R5 random read", addrs[$urandom_range(0, 7)], 32'hDEAD_BEEF);
      end

      // random pin levels (R6)
      for (int i = 0; i < 20; i++) begin
         logic [31:0] p;
         p = $urandom();
         @(negedge clk);
         pin_in = p;
         repeat (2) @(posedge clk);
         read_check("R6 random pins", 8'h70, p);
      end

      summary();
      $finish;
   end

endmodule